// File: doc/BRIEF.md
# PS/2 Controller Register Front End

This block is the bus-facing register layer of a single-port PS/2 keyboard or mouse controller. A host reaches it through a word-addressed request/acknowledge interface covering a 4 KB window. Behind it sit a receive FIFO that presents its head byte (show-ahead), a transmit path that takes one byte per push, and the line monitors of the serial engine. The serial bit engine, line timing and device protocol are outside this block.

The block keeps a control register and a clock-divisor register, remembers the most recently read receive byte, and assembles a status word from the transmit and receive state, the line levels and a parity bit taken from that remembered byte. It drives one interrupt request built from a gated receive term and an ungated transmit-enable term. It returns an eight-byte identification block from the top of the window. Undefined accesses read as zero and raise a one-cycle error flag.

Accesses are run by a two-state sequencer. In state ACC_IDLE, a high `bus_req` is taken ("accept" transition). All side effects happen on that edge and the sequencer moves to ACC_RESP. In ACC_RESP, `bus_ack` is high for exactly one cycle with the registered read data and error flag. The sequencer then always returns to ACC_IDLE ("release" transition). A requester holds `bus_req` and its fields steady until it sees `bus_ack`.

Top module: `ps2_regif`

## Requirements
- R1: After reset the control, clock-divisor and remembered-byte registers are zero. `irq_o`, `bus_ack`, `bus_err`, `tx_push` and `rx_pop` are low.
- R2: The register is chosen by `bus_addr[11:2]`: 0 control, 1 status, 2 data, 3 clock divisor, 4 interrupt status. Control (8 bits) and clock divisor (8 bits) read back what was last written to them in `bus_wdata[7:0]`.
- R3: `irq_o` = (receive FIFO non-empty AND control bit 4) OR control bit 3. It follows a control write from the cycle after the accepting edge.
- R4: The status word holds these bits, all higher bits zero: bit 6 `tx_empty`, bit 5 `tx_busy`, bit 4 receive FIFO non-empty, bit 3 `rx_busy`, bit 2 parity, bit 1 `line_clk`, bit 0 `line_dat`.
- R5: A data read with a non-empty FIFO returns the head byte, pulses `rx_pop` on the accepting edge and stores that byte as the remembered byte. With an empty FIFO it returns the remembered byte and does not pop.
- R6: Status bit 2 is the XOR of all eight bits of the remembered byte.
- R7: A data write raises `tx_push` for exactly the ACC_RESP cycle, with `tx_data` = `bus_wdata[7:0]`.
- R8: The interrupt status register reads bit 1 = 1 always and bit 0 = receive FIFO non-empty.
- R9: Reads of byte addresses 0xFE0 through 0xFFC return, one byte per word in rising address order, 0x50, 0x10, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R10: These accesses are undefined: a read of any other offset, and a write to any offset other than control, data or clock divisor. An undefined access reads zero, changes no register, pops nothing and sets `bus_err` during its ACC_RESP cycle only.
- R11: `bus_ack` rises in the cycle after a request is accepted in ACC_IDLE and stays high for exactly one cycle. Writes return zero read data.
- R12: Popping the last byte from the FIFO drops the receive interrupt term by the ACC_RESP cycle of that read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_req | input | 1 | Access request, held until acknowledged |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | One-cycle access acknowledge |
| bus_rdata | output | 32 | Read data, valid with bus_ack |
| bus_err | output | 1 | Undefined access, valid with bus_ack |
| irq_o | output | 1 | Interrupt request |
| rx_empty | input | 1 | Receive FIFO empty |
| rx_data | input | 8 | Receive FIFO head byte |
| rx_pop | output | 1 | Receive FIFO pop |
| rx_busy | input | 1 | Receiver shifting a frame |
| tx_empty | input | 1 | Transmitter has nothing queued |
| tx_busy | input | 1 | Transmitter shifting a frame |
| tx_push | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| line_clk | input | 1 | Sampled clock line level |
| line_dat | input | 1 | Sampled data line level |

## Verification
The register map is tried with a vector table. It covers writes and readbacks of control and divisor with different values, every ID word, and the words just below the ID block and in the gap. These vectors separate correct index decoding from aliasing and from out-of-range hits. The status word is read under two opposite settings of the line and transmit inputs, so that every bit position is shown to be wired to its own source. The receive path is driven with one odd-parity byte and one even-parity byte, and then read once more with the FIFO empty. This tells popping apart from re-reading, and it exposes parity taken from the wrong byte. The interrupt is tried with each enable bit alone and with the FIFO both full and empty, which separates the gated term from the ungated one.

// File: rtl/ps2_regif_pkg.sv
package ps2_regif_pkg;

    typedef enum logic {
        ACC_IDLE = 1'b0,
        ACC_RESP = 1'b1
    } acc_state_e;

    // register word indices (bus_addr[11:2])
    localparam int IDX_CTRL  = 0;
    localparam int IDX_STAT  = 1;
    localparam int IDX_DATA  = 2;
    localparam int IDX_CDIV  = 3;
    localparam int IDX_ISTAT = 4;

    localparam int ID_WORDS = 8;

    // control bits that feed the interrupt
    localparam int CTL_TX_IE = 3;
    localparam int CTL_RX_IE = 4;

    function automatic logic [7:0] id_byte(input logic [2:0] n);
        logic [7:0] b;
        unique case (n)
            3'd0: b = 8'h50;
            3'd1: b = 8'h10;
            3'd2: b = 8'h04;
            3'd3: b = 8'h00;
            3'd4: b = 8'h0D;
            3'd5: b = 8'hF0;
            3'd6: b = 8'h05;
            default: b = 8'hB1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/ps2_regif_fsm.sv
module ps2_regif_fsm
    import ps2_regif_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic bus_req,
    output logic accept,
    output logic acc_idle,
    output logic bus_ack
);

    acc_state_e st_q;
    acc_state_e st_d;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ACC_IDLE;
        else        st_q <= st_d;
    end

    // transitions: accept (IDLE->RESP), release (RESP->IDLE)
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ACC_IDLE: if (bus_req) st_d = ACC_RESP;
            ACC_RESP: st_d = ACC_IDLE;
            default:  st_d = ACC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        accept   = 1'b0;
        acc_idle = 1'b0;
        bus_ack  = 1'b0;
        unique case (st_q)
            ACC_IDLE: begin
                acc_idle = 1'b1;
                accept   = bus_req;
            end
            ACC_RESP: bus_ack = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/ps2_regif_decode.sv
module ps2_regif_decode
    import ps2_regif_pkg::*;
#(
    parameter int ADDR_W = 12,
    localparam int IDX_W = ADDR_W - 2
) (
    input  logic              accept,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    output logic [IDX_W-1:0]  idx,
    output logic              id_hit,
    output logic              wr_ctrl,
    output logic              wr_cdiv,
    output logic              wr_data,
    output logic              rd_data,
    output logic              acc_bad
);

    localparam int ID_BASE = (1 << IDX_W) - ID_WORDS;

    logic rd_ok;
    logic wr_ok;

    always_comb begin
        idx    = bus_addr[ADDR_W-1:2];
        id_hit = (idx >= IDX_W'(ID_BASE));
        rd_ok  = (idx <= IDX_W'(IDX_ISTAT)) || id_hit;
        wr_ok  = (idx == IDX_W'(IDX_CTRL)) || (idx == IDX_W'(IDX_DATA)) ||
                 (idx == IDX_W'(IDX_CDIV));
        wr_ctrl = accept &&  bus_we && (idx == IDX_W'(IDX_CTRL));
        wr_cdiv = accept &&  bus_we && (idx == IDX_W'(IDX_CDIV));
        wr_data = accept &&  bus_we && (idx == IDX_W'(IDX_DATA));
        rd_data = accept && !bus_we && (idx == IDX_W'(IDX_DATA));
        acc_bad = accept && (bus_we ? !wr_ok : !rd_ok);
    end

endmodule

// File: rtl/ps2_regif_regs.sv
module ps2_regif_regs #(
    parameter int CTRL_W = 8,
    parameter int DIV_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_ctrl,
    input  logic              wr_cdiv,
    input  logic              wr_data,
    input  logic              rd_data,
    input  logic [DATA_W-1:0] bus_wdata,
    input  logic              rx_empty,
    input  logic [7:0]        rx_data,
    output logic              rx_pop,
    output logic [CTRL_W-1:0] ctrl_q,
    output logic [DIV_W-1:0]  cdiv_q,
    output logic [7:0]        last_q,
    output logic              tx_push,
    output logic [7:0]        tx_data
);

    assign rx_pop = rd_data && !rx_empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q  <= '0;
            cdiv_q  <= '0;
            last_q  <= '0;
            tx_push <= 1'b0;
            tx_data <= '0;
        end else begin
            tx_push <= wr_data;
            if (wr_ctrl) ctrl_q  <= bus_wdata[CTRL_W-1:0];
            if (wr_cdiv) cdiv_q  <= bus_wdata[DIV_W-1:0];
            if (wr_data) tx_data <= bus_wdata[7:0];
            if (rx_pop)  last_q  <= rx_data;
        end
    end

endmodule

// File: rtl/ps2_regif_rdmux.sv
module ps2_regif_rdmux
    import ps2_regif_pkg::*;
#(
    parameter int IDX_W  = 10,
    parameter int CTRL_W = 8,
    parameter int DIV_W  = 8,
    parameter int DATA_W = 32
) (
    input  logic [IDX_W-1:0]  idx,
    input  logic              id_hit,
    input  logic [CTRL_W-1:0] ctrl_q,
    input  logic [DIV_W-1:0]  cdiv_q,
    input  logic [7:0]        last_q,
    input  logic              rx_empty,
    input  logic [7:0]        rx_data,
    input  logic              rx_busy,
    input  logic              tx_empty,
    input  logic              tx_busy,
    input  logic              line_clk,
    input  logic              line_dat,
    output logic [DATA_W-1:0] rd_val
);

    logic       pending;
    logic [6:0] stat;

    always_comb begin
        pending = !rx_empty;
        stat    = {tx_empty, tx_busy, pending, rx_busy, ^last_q, line_clk, line_dat};
        rd_val  = '0;
        if (id_hit) begin
            rd_val = DATA_W'(id_byte(idx[2:0]));
        end else begin
            unique case (int'(idx))
                IDX_CTRL:  rd_val = DATA_W'(ctrl_q);
                IDX_STAT:  rd_val = DATA_W'(stat);
                IDX_DATA:  rd_val = DATA_W'(pending ? rx_data : last_q);
                IDX_CDIV:  rd_val = DATA_W'(cdiv_q);
                IDX_ISTAT: rd_val = DATA_W'({1'b1, pending});
                default:   rd_val = '0;
            endcase
        end
    end

endmodule

// File: rtl/ps2_regif.sv
module ps2_regif
    import ps2_regif_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int DATA_W = 32,
    parameter int CTRL_W = 8,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_req,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic              bus_ack,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_err,
    output logic              irq_o,
    input  logic              rx_empty,
    input  logic [7:0]        rx_data,
    output logic              rx_pop,
    input  logic              rx_busy,
    input  logic              tx_empty,
    input  logic              tx_busy,
    output logic              tx_push,
    output logic [7:0]        tx_data,
    input  logic              line_clk,
    input  logic              line_dat
);

    localparam int IDX_W = ADDR_W - 2;

    logic              accept;
    logic              acc_idle;
    logic [IDX_W-1:0]  idx;
    logic              id_hit;
    logic              wr_ctrl, wr_cdiv, wr_data, rd_data, acc_bad;
    logic [CTRL_W-1:0] ctrl_q;
    logic [DIV_W-1:0]  cdiv_q;
    logic [7:0]        last_q;
    logic [DATA_W-1:0] rd_val;
    logic [DATA_W-1:0] rdata_q;
    logic              err_q;

    ps2_regif_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req),
        .accept(accept), .acc_idle(acc_idle), .bus_ack(bus_ack)
    );

    ps2_regif_decode #(.ADDR_W(ADDR_W)) u_dec (
        .accept(accept), .bus_we(bus_we), .bus_addr(bus_addr),
        .idx(idx), .id_hit(id_hit), .wr_ctrl(wr_ctrl), .wr_cdiv(wr_cdiv),
        .wr_data(wr_data), .rd_data(rd_data), .acc_bad(acc_bad)
    );

    ps2_regif_regs #(.CTRL_W(CTRL_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_ctrl(wr_ctrl), .wr_cdiv(wr_cdiv),
        .wr_data(wr_data), .rd_data(rd_data), .bus_wdata(bus_wdata),
        .rx_empty(rx_empty), .rx_data(rx_data), .rx_pop(rx_pop),
        .ctrl_q(ctrl_q), .cdiv_q(cdiv_q), .last_q(last_q),
        .tx_push(tx_push), .tx_data(tx_data)
    );

    ps2_regif_rdmux #(.IDX_W(IDX_W), .CTRL_W(CTRL_W), .DIV_W(DIV_W), .DATA_W(DATA_W)) u_mux (
        .idx(idx), .id_hit(id_hit), .ctrl_q(ctrl_q), .cdiv_q(cdiv_q),
        .last_q(last_q), .rx_empty(rx_empty), .rx_data(rx_data),
        .rx_busy(rx_busy), .tx_empty(tx_empty), .tx_busy(tx_busy),
        .line_clk(line_clk), .line_dat(line_dat), .rd_val(rd_val)
    );

    // response register, loaded on the accepting edge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rdata_q <= '0;
            err_q   <= 1'b0;
        end else begin
            err_q <= accept && acc_bad;
            if (accept) rdata_q <= (bus_we || acc_bad) ? '0 : rd_val;
        end
    end

    assign bus_rdata = rdata_q;
    assign bus_err   = err_q;
    assign irq_o     = (!rx_empty && ctrl_q[CTL_RX_IE]) || ctrl_q[CTL_TX_IE];

endmodule

// File: rtl/ps2_regif_chk.sv
module ps2_regif_chk #(
    parameter int ADDR_W = 12,
    parameter int CTRL_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_req,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              bus_err,
    input logic              irq_o,
    input logic              rx_empty,
    input logic              rx_pop,
    input logic              tx_push,
    input logic              acc_idle,
    input logic [CTRL_W-1:0] ctrl_q
);

    // R11: acknowledge lasts one cycle
    p_ack_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);

    // R10: error flag only alongside an acknowledge
    p_err_with_ack_r10: assert property (@(posedge clk) disable iff (!rst_n)
        bus_err |-> bus_ack);

    // R5: pops only from a non-empty FIFO on an accepted data read
    p_pop_data_read_r5: assert property (@(posedge clk) disable iff (!rst_n)
        rx_pop |-> (!rx_empty && acc_idle && bus_req && !bus_we &&
                    bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2)));

    // R7: a push follows an accepted data write
    p_push_after_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_push |-> $past(acc_idle && bus_req && bus_we &&
                          bus_addr[ADDR_W-1:2] == (ADDR_W-2)'(2)));

    // R3: transmit enable alone forces the request
    p_irq_tx_enable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_q[3] |-> irq_o);

    // R3: no enable term active means no request
    p_irq_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_empty && !ctrl_q[3]) |-> !irq_o);

endmodule

bind ps2_regif ps2_regif_chk #(.ADDR_W(ADDR_W), .CTRL_W(CTRL_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_ack(bus_ack), .bus_err(bus_err),
    .irq_o(irq_o), .rx_empty(rx_empty), .rx_pop(rx_pop),
    .tx_push(tx_push), .acc_idle(acc_idle), .ctrl_q(ctrl_q)
);

// File: tb/ps2_regif_test.sv
`timescale 1ns/100ps
module ps2_regif_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_req = 1'b0, bus_we = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic        bus_ack, bus_err, irq_o, rx_pop, tx_push;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_data, rx_data;
    logic        rx_empty;
    logic        rx_busy = 1'b0, tx_empty = 1'b1, tx_busy = 1'b0;
    logic        line_clk = 1'b1, line_dat = 1'b1;

    int n_chk = 0, n_err = 0;
    int pops = 0, pushes = 0;

    // receive FIFO model
    logic [7:0] fifo [8];
    int         cnt = 0;
    logic       ld_valid = 1'b0;
    logic [7:0] ld_byte = '0;

    assign rx_data  = fifo[0];
    assign rx_empty = (cnt == 0);

    initial for (int i = 0; i < 8; i++) fifo[i] = '0;

    always @(posedge clk) begin
        int c;
        c = cnt;
        if (rx_pop && c > 0) begin
            for (int i = 0; i < 7; i++) fifo[i] <= fifo[i+1];
            c = c - 1;
            pops <= pops + 1;
        end
        if (ld_valid && c < 8) begin
            fifo[c] <= ld_byte;
            c = c + 1;
        end
        cnt <= c;
        if (tx_push) pushes <= pushes + 1;
    end

    ps2_regif uut (
        .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_ack(bus_ack),
        .bus_rdata(bus_rdata), .bus_err(bus_err), .irq_o(irq_o),
        .rx_empty(rx_empty), .rx_data(rx_data), .rx_pop(rx_pop),
        .rx_busy(rx_busy), .tx_empty(tx_empty), .tx_busy(tx_busy),
        .tx_push(tx_push), .tx_data(tx_data), .line_clk(line_clk),
        .line_dat(line_dat)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    logic [31:0] rd;
    logic        er;
    int          lat;
    logic        seen_push;
    logic [7:0]  seen_txd;

    task automatic access(input logic we, input logic [11:0] a, input logic [31:0] wd);
        @(negedge clk);
        bus_req = 1'b1; bus_we = we; bus_addr = a; bus_wdata = wd;
        lat = 0;
        do begin
            @(negedge clk);
            lat++;
        end while (!bus_ack && lat < 20);
        rd = bus_rdata; er = bus_err;
        seen_push = tx_push; seen_txd = tx_data;
        bus_req = 1'b0; bus_we = 1'b0;
    endtask

    task automatic push_byte(input logic [7:0] b);
        @(negedge clk);
        ld_valid = 1'b1; ld_byte = b;
        @(negedge clk);
        ld_valid = 1'b0;
    endtask

    typedef struct packed {
        logic        we;
        logic [11:0] addr;
        logic [31:0] wdata;
        logic [31:0] exp;
        logic        err;
    } vec_t;

    localparam int NV = 22;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 12'h000, 32'h0000_0006, 32'h0, 1'b0},   // R2 ctrl write
        '{1'b0, 12'h000, 32'h0,         32'h6, 1'b0},   // R2 ctrl readback
        '{1'b1, 12'h00C, 32'h0000_01A5, 32'h0, 1'b0},   // R2 divisor write
        '{1'b0, 12'h00C, 32'h0,         32'hA5, 1'b0},  // R2 divisor readback
        '{1'b1, 12'h00C, 32'h0000_003C, 32'h0, 1'b0},
        '{1'b0, 12'h00C, 32'h0,         32'h3C, 1'b0},
        '{1'b1, 12'h000, 32'h0,         32'h0, 1'b0},
        '{1'b0, 12'h004, 32'h0,         32'h43, 1'b0},  // R4 status idle
        '{1'b0, 12'h010, 32'h0,         32'h2, 1'b0},   // R8 empty
        '{1'b0, 12'h014, 32'h0,         32'h0, 1'b1},   // R10 gap read
        '{1'b1, 12'h004, 32'hFF,        32'h0, 1'b1},   // R10 status write
        '{1'b1, 12'h010, 32'hFF,        32'h0, 1'b1},   // R10 istat write
        '{1'b0, 12'h800, 32'h0,         32'h0, 1'b1},   // R10 mid window
        '{1'b0, 12'hFDC, 32'h0,         32'h0, 1'b1},   // R10 below ID
        '{1'b0, 12'hFE0, 32'h0,         32'h50, 1'b0},  // R9
        '{1'b0, 12'hFE4, 32'h0,         32'h10, 1'b0},
        '{1'b0, 12'hFE8, 32'h0,         32'h04, 1'b0},
        '{1'b0, 12'hFEC, 32'h0,         32'h00, 1'b0},
        '{1'b0, 12'hFF0, 32'h0,         32'h0D, 1'b0},
        '{1'b0, 12'hFF4, 32'h0,         32'hF0, 1'b0},
        '{1'b0, 12'hFF8, 32'h0,         32'h05, 1'b0},
        '{1'b0, 12'hFFC, 32'h0,         32'hB1, 1'b0}
    };

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

    initial begin
        int p0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 irq", irq_o, 0);
        chk("R1 ack", bus_ack, 0);
        chk("R1 err", bus_err, 0);
        chk("R1 tx_push", tx_push, 0);
        chk("R1 rx_pop", rx_pop, 0);
        access(1'b0, 12'h000, 0); chk("R1 ctrl zero", rd, 0);
        access(1'b0, 12'h00C, 0); chk("R1 divisor zero", rd, 0);

        // R11 handshake timing
        access(1'b0, 12'h000, 0);
        chk("R11 ack latency", lat, 1);
        @(negedge clk); chk("R11 ack single", bus_ack, 0);

        // table walk (R2 R4 R8 R9 R10)
        foreach (VECS[i]) begin
            access(VECS[i].we, VECS[i].addr, VECS[i].wdata);
            chk($sformatf("R2/R9/R10 vec%0d data", i), rd, VECS[i].exp);
            chk($sformatf("R10 vec%0d err", i), er, VECS[i].err);
        end
        access(1'b0, 12'h00C, 0); chk("R10 divisor untouched", rd, 32'h3C);
        access(1'b0, 12'h000, 0); chk("R10 ctrl untouched", rd, 0);

        // R4 opposite inputs
        tx_empty = 0; tx_busy = 1; rx_busy = 1; line_clk = 0; line_dat = 1;
        access(1'b0, 12'h004, 0); chk("R4 status mixed", rd, 32'h29);
        tx_empty = 1; tx_busy = 0; rx_busy = 0; line_clk = 1; line_dat = 0;
        access(1'b0, 12'h004, 0); chk("R4 status mixed2", rd, 32'h42);
        line_dat = 1;

        // receive path
        push_byte(8'hA7);
        push_byte(8'h3C);
        @(negedge clk);
        access(1'b0, 12'h004, 0); chk("R4 rx full", rd, 32'h53);
        access(1'b0, 12'h010, 0); chk("R8 pending", rd, 32'h3);
        chk("R3 no enable", irq_o, 0);
        p0 = pops;
        access(1'b0, 12'h018, 0); chk("R10 gap read err", er, 1);
        @(negedge clk); chk("R10 no pop", pops, p0);
        access(1'b1, 12'h000, 32'h10); chk("R3 rx enable", irq_o, 1);
        access(1'b0, 12'h008, 0); chk("R5 first byte", rd, 32'hA7);
        chk("R12 still pending", irq_o, 1);
        access(1'b0, 12'h004, 0); chk("R6 odd parity", rd, 32'h57);
        access(1'b0, 12'h008, 0); chk("R5 second byte", rd, 32'h3C);
        chk("R12 irq dropped", irq_o, 0);
        @(negedge clk); chk("R5 pop count", pops, p0 + 2);
        access(1'b0, 12'h008, 0); chk("R5 empty rereads last", rd, 32'h3C);
        @(negedge clk); chk("R5 empty no pop", pops, p0 + 2);
        access(1'b0, 12'h004, 0); chk("R6 even parity", rd, 32'h43);
        access(1'b0, 12'h010, 0); chk("R8 empty again", rd, 32'h2);

        // R3 ungated term
        access(1'b1, 12'h000, 32'h08); chk("R3 tx enable", irq_o, 1);
        access(1'b1, 12'h000, 32'h00); chk("R3 cleared", irq_o, 0);

        // R7 transmit
        access(1'b1, 12'h008, 32'h1C5);
        chk("R7 push", seen_push, 1);
        chk("R7 tx_data", seen_txd, 8'hC5);
        chk("R11 write rdata", rd, 0);
        @(negedge clk);
        chk("R7 push single", tx_push, 0);
        chk("R7 push count", pushes, 1);

        finish_run();
    end

endmodule